// File: doc/BRIEF.md
# Link training read FIFO

This block is the pattern store that a DRAM controller uses while it trains the data interface of the link. It holds six entries, and each entry is one complete burst of eight 32-bit beats. The controller can fill an entry in two ways:

- One beat at a time, with load commands that carry the beat data on the bank and address fields.
- In one pass, with a write-training command followed by a normal eight-beat write burst.

Training reads then return the entries in rotation. Each read gives one eight-beat burst on the read data port, and nothing is removed from the store, so one pattern can be replayed as often as the eye search needs.

Commands arrive already decoded on a two-bit operation field, together with the bank and address fields sampled in the same cycle. The write pointer and the read pointer are separate, and each wraps after the last entry.

Top module: `link_trn_fifo`

## Requirements
- R1: After reset both pointers are at entry 0, every stored beat reads as zero, and rd_valid_o and rd_data_o are low.
- R2: A load command (cmd_op_i = 2'b01) accepted while no write capture is pending writes one beat of the entry at the write pointer. The beat position is bank_i[2:0]. Each lane j receives bit (j mod 11) of the 11-bit value {bank_i[3], addr_i[9:0]}, where bit 0 is addr_i[0].
- R3: A load moves the write pointer on by one only when its beat position is 7. Loads at any other position leave the pointer where it is.
- R4: A write-training command (cmd_op_i = 2'b10) starts a capture. The next eight cycles with wdata_valid_i high store wdata_i into beats 0 to 7 of the entry at the write pointer, in order. After the eighth beat the write pointer moves on by one.
- R5: While a capture is pending, load and write-training commands are ignored. Cycles with wdata_valid_i low store nothing.
- R6: A read-training command (cmd_op_i = 2'b11) accepted while no read burst is running raises rd_valid_o for exactly eight consecutive cycles, starting in the cycle after the command. The k-th of these cycles carries beat k-1 of the entry at the read pointer, and the read pointer moves on by one.
- R7: A read-training command issued while a read burst is running is ignored and does not move the read pointer.
- R8: Both pointers wrap from entry 5 back to entry 0. Reads do not clear entries, so the seventh read after reset returns the same entry as the first.
- R9: rd_data_o is zero in every cycle in which rd_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_op_i | input | 2 | Decoded command: 00 idle, 01 load, 10 write-training, 11 read-training |
| bank_i | input | 4 | Bank field; for a load, bits 2:0 give the beat position and bit 3 gives data bit 10 |
| addr_i | input | 10 | Address field; for a load, the data bits 9:0 |
| wdata_valid_i | input | 1 | Write burst beat valid |
| wdata_i | input | 32 | Write burst beat data |
| rd_valid_o | output | 1 | Training read beat valid |
| rd_data_o | output | 32 | Training read beat data |

## Verification
The bench targets these corner cases:

- **Stalled write burst.** A burst with gaps in wdata_valid_i must not lose beats. A capture counter that advanced on idle cycles would shift the pattern.
- **Commands during a capture.** Load and write-training commands issued during a capture must be dropped. A design that accepted them would corrupt the entry or restart the capture.
- **Partial load sequences.** A design that advanced on every load would spread one pattern over several entries.
- **Read during a running burst.** A design that queued or restarted the read would skip an entry or cut a burst short.
- **Wrap-around.** More than six reads and more than six fills exercise the pointer wrap, where an off-by-one in the modulo would return the wrong pattern on the replay.

// File: rtl/ltf_pkg.sv
package ltf_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_LOAD   = 2'b01,
    OP_WTRAIN = 2'b10,
    OP_RTRAIN = 2'b11
  } ltf_op_e;
endpackage

// File: rtl/ltf_lane_spread.sv
module ltf_lane_spread #(
  parameter int IN_W  = 11,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] lanes_o
);
  for (genvar j = 0; j < OUT_W; j++) begin : g_lane
    assign lanes_o[j] = val_i[j % IN_W];
  end
endmodule

// File: rtl/ltf_wrap_ptr.sv
module ltf_wrap_ptr #(
  parameter int DEPTH = 6,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/ltf_beat_store.sv
module ltf_beat_store #(
  parameter int DEPTH  = 6,
  parameter int BEATS  = 8,
  parameter int WIDTH  = 32,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  w_ent_i,
  input  logic [BEAT_W-1:0] w_beat_i,
  input  logic [WIDTH-1:0]  w_data_i,
  input  logic [PTR_W-1:0]  r_ent_i,
  input  logic [BEAT_W-1:0] r_beat_i,
  output logic [WIDTH-1:0]  r_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH][BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++)
        for (int b = 0; b < BEATS; b++)
          mem_q[e][b] <= '0;
    end else if (we_i) begin
      mem_q[w_ent_i][w_beat_i] <= w_data_i;
    end
  end

  assign r_data_o = mem_q[r_ent_i][r_beat_i];
endmodule

// File: rtl/link_trn_fifo.sv
module link_trn_fifo
  import ltf_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int BEATS  = 8,
  parameter int WIDTH  = 32,
  parameter int BANK_W = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_op_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_valid_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic              rd_valid_o,
  output logic [WIDTH-1:0]  rd_data_o
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int LD_W   = ADDR_W + 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  ltf_op_e op;
  assign op = ltf_op_e'(cmd_op_i);

  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, rd_ent_q;
  logic [BEAT_W-1:0] wbeat_q, rd_beat_q, rd_beat_nx;
  logic              wr_busy_q, rd_busy_q;
  logic              is_load, is_wtr, is_rtr, cap, wr_adv;
  logic [WIDTH-1:0]  ld_lanes, st_wdata, st_rdata;
  logic [BEAT_W-1:0] st_wbeat, st_rbeat;
  logic [PTR_W-1:0]  st_rent;

  assign is_load = (op == OP_LOAD)   && !wr_busy_q;
  assign is_wtr  = (op == OP_WTRAIN) && !wr_busy_q;
  assign is_rtr  = (op == OP_RTRAIN) && !rd_busy_q;
  assign cap     = wr_busy_q && wdata_valid_i;

  ltf_lane_spread #(.IN_W(LD_W), .OUT_W(WIDTH)) u_spread (
    .val_i   ({bank_i[BANK_W-1], addr_i}),
    .lanes_o (ld_lanes)
  );

  assign st_wbeat = is_load ? bank_i[BEAT_W-1:0] : wbeat_q;
  assign st_wdata = is_load ? ld_lanes : wdata_i;
  assign wr_adv   = (is_load && bank_i[BEAT_W-1:0] == LAST_BEAT)
                 || (cap && wbeat_q == LAST_BEAT);

  // write capture sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_busy_q <= 1'b0;
      wbeat_q   <= '0;
    end else if (is_wtr) begin
      wr_busy_q <= 1'b1;
      wbeat_q   <= '0;
    end else if (cap) begin
      wbeat_q <= wbeat_q + 1'b1;
      if (wbeat_q == LAST_BEAT) wr_busy_q <= 1'b0;
    end
  end

  ltf_wrap_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk_i, .rst_ni, .adv_i(wr_adv), .ptr_o(wr_ptr_q)
  );

  ltf_wrap_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk_i, .rst_ni, .adv_i(is_rtr), .ptr_o(rd_ptr_q)
  );

  assign rd_beat_nx = rd_beat_q + 1'b1;
  assign st_rent    = is_rtr ? rd_ptr_q : rd_ent_q;
  assign st_rbeat   = is_rtr ? '0 : rd_beat_nx;

  ltf_beat_store #(.DEPTH(DEPTH), .BEATS(BEATS), .WIDTH(WIDTH)) u_store (
    .clk_i, .rst_ni,
    .we_i     (is_load || cap),
    .w_ent_i  (wr_ptr_q),
    .w_beat_i (st_wbeat),
    .w_data_i (st_wdata),
    .r_ent_i  (st_rent),
    .r_beat_i (st_rbeat),
    .r_data_o (st_rdata)
  );

  // read burst sequencing; outputs registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_busy_q <= 1'b0;
      rd_ent_q  <= '0;
      rd_beat_q <= '0;
      rd_data_o <= '0;
    end else if (is_rtr) begin
      rd_busy_q <= 1'b1;
      rd_ent_q  <= rd_ptr_q;
      rd_beat_q <= '0;
      rd_data_o <= st_rdata;
    end else if (rd_busy_q) begin
      if (rd_beat_q == LAST_BEAT) begin
        rd_busy_q <= 1'b0;
        rd_data_o <= '0;
      end else begin
        rd_beat_q <= rd_beat_nx;
        rd_data_o <= st_rdata;
      end
    end
  end

  assign rd_valid_o = rd_busy_q;
endmodule

// File: rtl/link_trn_fifo_chk.sv
module link_trn_fifo_chk #(
  parameter int DEPTH  = 6,
  parameter int BEATS  = 8,
  parameter int WIDTH  = 32,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int BEAT_W = $clog2(BEATS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cmd_op_i,
  input logic [3:0]       bank_i,
  input logic             wdata_valid_i,
  input logic             rd_valid_o,
  input logic [WIDTH-1:0] rd_data_o,
  input logic [PTR_W-1:0] wr_ptr_q,
  input logic [PTR_W-1:0] rd_ptr_q,
  input logic             wr_busy_q,
  input logic             rd_busy_q
);
  logic [BEAT_W+1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             run_q <= '0;
    else if (!rd_valid_o)                    run_q <= '0;
    else if (run_q != (BEAT_W+2)'(BEATS+1))  run_q <= run_q + 1'b1;
  end

  // R6
  burst_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> run_q < (BEAT_W+2)'(BEATS));

  // R6
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_valid_o) |-> run_q == (BEAT_W+2)'(BEATS));

  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> rd_data_o == '0);

  // R8
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_q < PTR_W'(DEPTH)) && (rd_ptr_q < PTR_W'(DEPTH)));

  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_q |=> $stable(rd_ptr_q));

  // R3
  load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_busy_q && cmd_op_i == 2'b01 && bank_i[2:0] != 3'd7) |=> $stable(wr_ptr_q));

  // R5
  cap_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_busy_q && !wdata_valid_i) |=> ($stable(wr_ptr_q) && wr_busy_q));
endmodule

bind link_trn_fifo link_trn_fifo_chk #(.DEPTH(DEPTH), .BEATS(BEATS), .WIDTH(WIDTH)) u_chk (
  .clk_i, .rst_ni, .cmd_op_i, .bank_i, .wdata_valid_i, .rd_valid_o, .rd_data_o,
  .wr_ptr_q, .rd_ptr_q, .wr_busy_q, .rd_busy_q
);

// File: tb/link_trn_fifo_bench.sv
module link_trn_fifo_bench;
  localparam int N = 6;
  localparam int B = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cmd_op_i = 2'b00;
  logic [3:0]  bank_i = '0;
  logic [9:0]  addr_i = '0;
  logic        wdata_valid_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  link_trn_fifo u_link_trn_fifo (.*);

  always #5 clk_i = ~clk_i;

  // behavioural reference model
  logic [31:0] mm [N][B];
  int mwp, mrp, mwbeat, ment, mbeat;
  bit mwb, mrb, exp_valid;
  logic [31:0] exp_data;

  function automatic logic [31:0] spread(input logic [3:0] b, input logic [9:0] a);
    logic [10:0] v = {b[3], a};
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = v[j % 11];
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N; e++) for (int k = 0; k < B; k++) mm[e][k] = '0;
      mwp = 0; mrp = 0; mwbeat = 0; ment = 0; mbeat = 0;
      mwb = 0; mrb = 0; exp_valid = 0; exp_data = '0;
    end else begin
      bit ld, wt, rt, cp;
      ld = (cmd_op_i == 2'b01) && !mwb;
      wt = (cmd_op_i == 2'b10) && !mwb;
      rt = (cmd_op_i == 2'b11) && !mrb;
      cp = mwb && wdata_valid_i;
      if (rt) begin
        exp_valid = 1; exp_data = mm[mrp][0]; ment = mrp; mbeat = 0; mrb = 1;
        mrp = (mrp + 1) % N;
      end else if (mrb) begin
        if (mbeat == B - 1) begin mrb = 0; exp_valid = 0; exp_data = '0; end
        else begin mbeat++; exp_data = mm[ment][mbeat]; end
      end
      if (ld) begin
        mm[mwp][bank_i[2:0]] = spread(bank_i, addr_i);
        if (bank_i[2:0] == 3'd7) mwp = (mwp + 1) % N;
      end
      if (cp) begin
        mm[mwp][mwbeat] = wdata_i;
        if (mwbeat == B - 1) begin mwb = 0; mwp = (mwp + 1) % N; end
        else mwbeat++;
      end
      if (wt) begin mwb = 1; mwbeat = 0; end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (rd_valid_o !== exp_valid || rd_data_o !== exp_data) begin
        errors++;
        $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h",
                 cur_req, rd_valid_o, rd_data_o, exp_valid, exp_data);
      end
    end
  end

  task automatic cyc(input logic [1:0] op, input logic [3:0] b, input logic [9:0] a,
                     input logic v, input logic [31:0] d);
    @(negedge clk_i);
    cmd_op_i = op; bank_i = b; addr_i = a; wdata_valid_i = v; wdata_i = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(2'b00, 4'h0, 10'h0, 1'b0, 32'h0);
  endtask

  task automatic rd_train();
    cyc(2'b11, 4'h0, 10'h0, 1'b0, 32'h0);
    idle(9);
  endtask

  task automatic load_entry(input int seed);
    for (int k = 0; k < B; k++)
      cyc(2'b01, {seed[0] ^ k[0], k[2:0]}, 10'(seed * 37 + k * 91), 1'b0, 32'h0);
  endtask

  task automatic wtrain(input int seed, input bit gaps);
    cyc(2'b10, 4'h0, 10'h0, 1'b0, 32'h0);
    for (int k = 0; k < B; k++) begin
      if (gaps && k[0]) cyc(2'b00, 4'h0, 10'h0, 1'b0, 32'hDEAD_BEEF);
      cyc(2'b00, 4'h0, 10'h0, 1'b1, 32'(seed) * 32'h0101_0101 ^ 32'(k) << 4);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state at the ports
    checks++;
    if (rd_valid_o !== 1'b0 || rd_data_o !== 32'h0) begin
      errors++;
      $display("FAIL R1: valid=%b data=%h expected valid=0 data=0", rd_valid_o, rd_data_o);
    end
    rst_ni = 1'b1;
    idle(2);
    cur_req = "R1"; rd_train();                         // zero entry 0
    cur_req = "R2"; load_entry(3); rd_train();          // entry 0 loaded, read 1 -> entry 1 (zero)
    cur_req = "R3";
    for (int k = 0; k < 4; k++) cyc(2'b01, 4'(k), 10'h3FF - 10'(k), 1'b0, 32'h0);
    for (int k = 4; k < B; k++) cyc(2'b01, 4'h8 | 4'(k), 10'(k * 5), 1'b0, 32'h0);
    rd_train();                                         // entry 2 still zero, entry 1 filled
    cur_req = "R4"; wtrain(7, 1'b0); wtrain(9, 1'b1);   // entries 2,3
    rd_train(); rd_train();                             // reads entries 3... (model tracks)
    cur_req = "R5";
    cyc(2'b10, 4'h0, 10'h0, 1'b0, 32'h0);
    cyc(2'b01, 4'h7, 10'h155, 1'b0, 32'h0);             // ignored load
    cyc(2'b10, 4'h0, 10'h0, 1'b1, 32'h1111_0000);
    cyc(2'b10, 4'h0, 10'h0, 1'b0, 32'h0);               // ignored restart
    for (int k = 1; k < B; k++) cyc(2'b00, 4'h0, 10'h0, 1'b1, 32'h1111_0000 + 32'(k));
    idle(2);
    cur_req = "R6"; rd_train(); rd_train();
    cur_req = "R7";
    cyc(2'b11, 4'h0, 10'h0, 1'b0, 32'h0);
    cyc(2'b11, 4'h0, 10'h0, 1'b0, 32'h0);
    cyc(2'b11, 4'h0, 10'h0, 1'b0, 32'h0);
    idle(10);
    cur_req = "R8";
    load_entry(11); wtrain(13, 1'b1); load_entry(17);
    for (int i = 0; i < 8; i++) rd_train();
    cur_req = "R9"; idle(5);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule